// File: doc/BRIEF.md
# Shared-Adder Priority Datapath

This block picks one of several additions according to two priority-ordered condition bits, and it computes every one of them on a single adder. It never builds one adder per branch with a multiplexer behind them. Instead, two operand multiplexers steer the correct pair of values into the one carry chain. The multiplexers are driven by the same condition bits that would otherwise select among finished sums.

A mode input selects between two uses of that adder. In single-result mode, the block produces one sum: a+b, a+c, or d+1. In dual-result mode, it produces two results, x and y. The addition goes to one of them, and the other takes a fixed fill value.

All outputs are registered on the rising clock edge. Every sum keeps only the low W bits, and the carry out of the top bit is dropped.

Top module: `shared_add_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, `res_q`, `x_q` and `y_q` all become zero on that edge.
- R2: With `dual_mode`=0 and `cond_hi`=1, `res_q` after the next edge equals (a+b) mod 2^W, whatever `cond_lo` is.
- R3: With `dual_mode`=0, `cond_hi`=0 and `cond_lo`=1, `res_q` after the next edge equals (a+c) mod 2^W.
- R4: With `dual_mode`=0 and both conditions 0, `res_q` after the next edge equals (d+1) mod 2^W.
- R5: The carry out of the top bit is discarded. For example, with W=8, 8'hFF + 8'h01 gives 8'h00, and d=8'hFF in the R4 case gives 8'h00.
- R6: With `dual_mode`=1 and `cond_hi`=1, after the next edge `x_q` = (a+b) mod 2^W, `y_q` = 0, and `res_q` equals `x_q`.
- R7: With `dual_mode`=1 and `cond_hi`=0, after the next edge `x_q` is all ones, `y_q` = (c+d) mod 2^W, and `res_q` equals `y_q`.
- R8: In dual-result mode, `cond_lo` has no effect on any output.
- R9: In single-result mode, `x_q` and `y_q` are zero after each edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 0: single-result mode, 1: dual-result mode |
| cond_hi | input | 1 | Higher-priority condition |
| cond_lo | input | 1 | Lower-priority condition (single-result mode only) |
| op_a | input | W | Operand a |
| op_b | input | W | Operand b |
| op_c | input | W | Operand c |
| op_d | input | W | Operand d |
| res_q | output | W | Registered output of the shared adder |
| x_q | output | W | Registered first result of dual-result mode |
| y_q | output | W | Registered second result of dual-result mode |

## Verification
Every result is due exactly one rising edge after the inputs that produced it are presented. The output registers are the only state between the operands and the ports.

The driver applies each stimulus on a falling edge and queues the expected triple it computes with one separate addition per branch. The monitor pops one entry a quarter period after each rising edge that followed a queued stimulus, so each comparison lands on the cycle the registered result appears. Directed wrap-around operands, every combination of the condition bits in both modes, and random operands feed the same queue.

// File: rtl/shared_add_pkg.sv
package shared_add_pkg;

  // Which operand pair the routing multiplexers present to the adder
  typedef enum logic [1:0] {
    PICK_AB = 2'd0,
    PICK_AC = 2'd1,
    PICK_D1 = 2'd2,
    PICK_CD = 2'd3
  } pick_e;

endpackage

// File: rtl/shared_add_route.sv
module shared_add_route
  import shared_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         dual_mode,
  input  logic         cond_hi,
  input  logic         cond_lo,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  output pick_e        pick,
  output logic [W-1:0] lhs,
  output logic [W-1:0] rhs
);

  localparam logic [W-1:0] ONE = W'(1);

  // Priority decode: cond_hi wins; cond_lo only matters in single mode
  always_comb begin
    if (cond_hi)        pick = PICK_AB;
    else if (dual_mode) pick = PICK_CD;
    else if (cond_lo)   pick = PICK_AC;
    else                pick = PICK_D1;
  end

  // Left operand multiplexer
  always_comb begin
    unique case (pick)
      PICK_AB, PICK_AC: lhs = op_a;
      PICK_D1:          lhs = op_d;
      default:          lhs = op_c;
    endcase
  end

  // Right operand multiplexer
  always_comb begin
    unique case (pick)
      PICK_AB: rhs = op_b;
      PICK_AC: rhs = op_c;
      PICK_D1: rhs = ONE;
      default: rhs = op_d;
    endcase
  end

endmodule

// File: rtl/shared_add_adder.sv
module shared_add_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic [W-1:0] sum
);

  // Internal carries only; the carry out of the top bit is never formed
  logic [W-1:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = lhs[i] ^ rhs[i] ^ carry[i];
    if (i < W - 1) begin : g_carry
      assign carry[i+1] = (lhs[i] & rhs[i]) | (carry[i] & (lhs[i] ^ rhs[i]));
    end
  end

endmodule

// File: rtl/shared_add_map.sv
module shared_add_map
  import shared_add_pkg::*;
#(
  parameter int W = 8
) (
  input  pick_e        pick,
  input  logic         dual_mode,
  input  logic [W-1:0] sum,
  output logic [W-1:0] x_d,
  output logic [W-1:0] y_d
);

  localparam logic [W-1:0] ALL_ONES = '1;

  // Steer the one sum into x or y and fill the other slot
  always_comb begin
    x_d = '0;
    y_d = '0;
    if (dual_mode) begin
      if (pick == PICK_AB) begin
        x_d = sum;
      end else begin
        x_d = ALL_ONES;
        y_d = sum;
      end
    end
  end

endmodule

// File: rtl/shared_add_datapath.sv
module shared_add_datapath
  import shared_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dual_mode,
  input  logic         cond_hi,
  input  logic         cond_lo,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic [W-1:0] op_d,
  output logic [W-1:0] res_q,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q
);

  pick_e        pick;
  logic [W-1:0] lhs;
  logic [W-1:0] rhs;
  logic [W-1:0] sum;
  logic [W-1:0] x_d;
  logic [W-1:0] y_d;

  shared_add_route #(.W(W)) route_i (
    .dual_mode (dual_mode),
    .cond_hi   (cond_hi),
    .cond_lo   (cond_lo),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .op_d      (op_d),
    .pick      (pick),
    .lhs       (lhs),
    .rhs       (rhs)
  );

  shared_add_adder #(.W(W)) adder_i (
    .lhs (lhs),
    .rhs (rhs),
    .sum (sum)
  );

  shared_add_map #(.W(W)) map_i (
    .pick      (pick),
    .dual_mode (dual_mode),
    .sum       (sum),
    .x_d       (x_d),
    .y_d       (y_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
    end else begin
      res_q <= sum;
      x_q   <= x_d;
      y_q   <= y_d;
    end
  end

endmodule

// File: rtl/shared_add_datapath_chk.sv
module shared_add_datapath_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         dual_mode,
  input logic         cond_hi,
  input logic         cond_lo,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [W-1:0] op_c,
  input logic [W-1:0] op_d,
  input logic [W-1:0] res_q,
  input logic [W-1:0] x_q,
  input logic [W-1:0] y_q
);

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && x_q == '0 && y_q == '0));

  a_r2_hi_ab: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode) && $past(cond_hi))
      |-> res_q == W'($past(op_a) + $past(op_b)));

  a_r3_lo_ac: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode) && !$past(cond_hi) && $past(cond_lo))
      |-> res_q == W'($past(op_a) + $past(op_c)));

  // R5: the d+1 case wraps because the result is cut to W bits
  a_r4_none_inc: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode) && !$past(cond_hi) && !$past(cond_lo))
      |-> res_q == W'($past(op_d) + W'(1)));

  a_r6_dual_x: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode) && $past(cond_hi))
      |-> (x_q == W'($past(op_a) + $past(op_b)) && y_q == '0 && res_q == x_q));

  a_r7_dual_y: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dual_mode) && !$past(cond_hi))
      |-> (x_q == '1 && y_q == W'($past(op_c) + $past(op_d)) && res_q == y_q));

  a_r9_single_xy_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(dual_mode)) |-> (x_q == '0 && y_q == '0));

endmodule

bind shared_add_datapath shared_add_datapath_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .dual_mode (dual_mode),
  .cond_hi   (cond_hi),
  .cond_lo   (cond_lo),
  .op_a      (op_a),
  .op_b      (op_b),
  .op_c      (op_c),
  .op_d      (op_d),
  .res_q     (res_q),
  .x_q       (x_q),
  .y_q       (y_q)
);

// File: tb/shared_add_datapath_tb_top.sv
module shared_add_datapath_tb_top;

  localparam int W      = 8;
  localparam int PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         dual_mode = 1'b0;
  logic         cond_hi = 1'b0;
  logic         cond_lo = 1'b0;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [W-1:0] op_c = '0;
  logic [W-1:0] op_d = '0;
  logic [W-1:0] res_q;
  logic [W-1:0] x_q;
  logic [W-1:0] y_q;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [W-1:0] q_res[$];
  logic [W-1:0] q_x[$];
  logic [W-1:0] q_y[$];
  string        q_tag[$];

  always #(PERIOD/2) clk = ~clk;

  shared_add_datapath #(.W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .dual_mode (dual_mode),
    .cond_hi   (cond_hi),
    .cond_lo   (cond_lo),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .op_d      (op_d),
    .res_q     (res_q),
    .x_q       (x_q),
    .y_q       (y_q)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one stimulus on a falling edge, queue the reference result
  task automatic drive(string tag, bit dm, bit hi, bit lo,
                       logic [W-1:0] a, logic [W-1:0] b,
                       logic [W-1:0] c, logic [W-1:0] d);
    logic [W-1:0] e_res, e_x, e_y;
    logic [W-1:0] s_ab, s_ac, s_d1, s_cd;
    @(negedge clk);
    dual_mode = dm; cond_hi = hi; cond_lo = lo;
    op_a = a; op_b = b; op_c = c; op_d = d;
    s_ab = a + b;
    s_ac = a + c;
    s_d1 = d + W'(1);
    s_cd = c + d;
    if (!dm) begin
      e_res = hi ? s_ab : (lo ? s_ac : s_d1);
      e_x = '0;
      e_y = '0;
    end else if (hi) begin
      e_res = s_ab; e_x = s_ab; e_y = '0;
    end else begin
      e_res = s_cd; e_x = '1; e_y = s_cd;
    end
    q_res.push_back(e_res);
    q_x.push_back(e_x);
    q_y.push_back(e_y);
    q_tag.push_back(tag);
  endtask

  // Monitor: results are due one rising edge after the stimulus
  always @(posedge clk) begin
    #(PERIOD/4);
    if (q_res.size() != 0) begin
      string t;
      t = q_tag.pop_front();
      check({t, " res"}, res_q, q_res.pop_front());
      check({t, " x"},   x_q,   q_x.pop_front());
      check({t, " y"},   y_q,   q_y.pop_front());
    end
  end

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin
    // R1: drive busy inputs during reset, outputs must still clear
    dual_mode = 1'b1; cond_hi = 1'b1;
    op_a = 8'h5A; op_b = 8'h33; op_c = 8'h11; op_d = 8'h77;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    check("R1 res", res_q, '0);
    check("R1 x", x_q, '0);
    check("R1 y", y_q, '0);
    @(negedge clk);
    rst = 1'b0;

    // Directed cases
    drive("R2 hi lo0", 0, 1, 0, 8'h12, 8'h34, 8'hAA, 8'hBB);
    drive("R2 hi lo1", 0, 1, 1, 8'h40, 8'h05, 8'h99, 8'h01);
    drive("R3 lo",     0, 0, 1, 8'h21, 8'h77, 8'h10, 8'h55);
    drive("R4 inc",    0, 0, 0, 8'h21, 8'h77, 8'h10, 8'h41);
    drive("R5 wrap ab",0, 1, 0, 8'hFF, 8'h01, 8'h00, 8'h00);
    drive("R5 wrap ac",0, 0, 1, 8'h80, 8'h00, 8'h80, 8'h00);
    drive("R5 wrap d", 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'hFF);
    drive("R6 dual hi",1, 1, 0, 8'h0F, 8'hF0, 8'h33, 8'h44);
    drive("R7 dual lo",1, 0, 0, 8'h0F, 8'hF0, 8'hC8, 8'h64);
    drive("R8 dual hi lo1", 1, 1, 1, 8'h0F, 8'hF0, 8'h33, 8'h44);
    drive("R8 dual lo lo1", 1, 0, 1, 8'h0F, 8'hF0, 8'hC8, 8'h64);
    drive("R9 single", 0, 0, 1, 8'hFE, 8'hFE, 8'hFE, 8'hFE);

    // Random operands over every mode/condition combination
    for (int i = 0; i < 400; i++) begin
      bit [2:0] k;
      k = 3'(i);
      drive(k[2] ? "R6 R7 R8 rnd" : "R2 R3 R4 R9 rnd",
            k[2], k[1], k[0],
            W'($urandom), W'($urandom), W'($urandom), W'($urandom));
    end

    @(negedge clk);
    wait (q_res.size() == 0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

endmodule